// File: doc/BRIEF.md
# Sixteen-Pin GPIO Controller with Edge Interrupts

The block controls sixteen general-purpose pins from a small 16-bit register bus that uses linear byte offsets. Software sets each pin's output level, its direction and a separate driver-release (tri-state) control. It reads back the live pin levels and picks, for each pin, whether a rising or a falling edge raises an interrupt. Pad logic receives per-pin output-enable and output-value signals and returns the sampled pad levels.

Pad inputs are asynchronous. They pass through a two-flop synchroniser before any register or edge logic sees them. An edge of the chosen polarity on an enabled pin latches a per-pin pending flag. The single interrupt line is the OR of those flags. Software clears flags by writing ones to a dedicated clear/status offset. When a new edge and a clear of the same pin fall in the same cycle, the edge is kept.

The bus is a one-cycle access: `req_i` with `we_i` high writes on the next rising clock edge. With `we_i` low, `rdata_o` shows the addressed register combinationally during the request cycle.

Top module: `gpio16_ctrl`

## Requirements
- R1: After reset, the registers at offsets 0x02, 0x04, 0x06, 0x08, 0x0A and 0x0C read 0x0000, and `pad_oe_o`, `pad_o` and `irq_o` are all 0.
- R2: A write to 0x02 (output level), 0x04 (direction, 1 = output), 0x06 (release, 1 = driver off), 0x08 (edge select, 1 = rising, 0 = falling) or 0x0A (interrupt enable, 1 = on) stores the word, and a read of that offset returns it. Bit n belongs to pin n.
- R3: `pad_oe_o[n]` is 1 only when direction bit n is 1 and release bit n is 0. `pad_o` equals the output-level register.
- R4: A read of offset 0x00 returns the synchronised pad levels (1 = high). A pad change becomes visible on a read after the second rising edge that follows it. This includes pins driven as outputs, which read back the level present on the pad.
- R5: On a pin whose enable bit is 1, a rising edge (when its edge-select bit is 1) or a falling edge (when it is 0) sets pending bit n. The bit reads as 1 at offset 0x0C, and `irq_o` rises, after the third rising edge that follows the pad change.
- R6: An edge on a pin whose enable bit is 0, or an edge of the opposite polarity, leaves the pending bits unchanged.
- R7: Writing 1 to bit n of 0x0C clears pending bit n on that write's clock edge. Writing 0 leaves the bit unchanged. A read of 0x0A returns the enable bits only.
- R8: If a new qualifying edge sets pending bit n in the same cycle that a write clears it, the bit stays set.
- R9: Writes to undefined offsets (0x0E and any odd offset) and to the read-only offset 0x00 change no register. Reads from undefined offsets return 0x0000.
- R10: `irq_o` is 1 exactly when at least one pending bit is set. It stays 1 while any pending bit remains after a partial clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 4 | Byte offset |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, valid while `req_i` is high and `we_i` is low |
| pad_i | input | 16 | Pad input levels |
| pad_o | output | 16 | Pad output levels |
| pad_oe_o | output | 16 | Pad driver enables |
| irq_o | output | 1 | Interrupt, OR of pending bits |

## Verification
The assertions assume that `req_i`, `we_i`, `addr_i` and `wdata_i` are stable around each rising edge. They also assume that `pad_i` changes at most once per pin per cycle, so that the edge logic sees one transition at a time. The bench changes every bus and pad input just after a rising edge. It models the pad as the driven value where the driver is enabled and as an external level elsewhere. The clear-versus-edge collision is placed in an exact cycle by counting the synchroniser and edge registers from the pad change.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] OFS_IN   = 4'h0;
  localparam logic [ADDR_W-1:0] OFS_OUT  = 4'h2;
  localparam logic [ADDR_W-1:0] OFS_DIR  = 4'h4;
  localparam logic [ADDR_W-1:0] OFS_REL  = 4'h6;
  localparam logic [ADDR_W-1:0] OFS_POL  = 4'h8;
  localparam logic [ADDR_W-1:0] OFS_IEN  = 4'hA;
  localparam logic [ADDR_W-1:0] OFS_PEND = 4'hC;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [W-1:0]      wdata_i,
  output logic [W-1:0]      rdata_o,
  input  logic [W-1:0]      in_val_i,
  input  logic [W-1:0]      pend_i,
  output logic [W-1:0]      out_o,
  output logic [W-1:0]      dir_o,
  output logic [W-1:0]      rel_o,
  output logic [W-1:0]      pol_o,
  output logic [W-1:0]      ien_o,
  output logic [W-1:0]      clr_o
);
  logic wr;
  logic hit_in, hit_out, hit_dir, hit_rel, hit_pol, hit_ien, hit_pend, addr_ok;

  assign wr       = req_i & we_i;
  assign hit_in   = (addr_i == OFS_IN);
  assign hit_out  = (addr_i == OFS_OUT);
  assign hit_dir  = (addr_i == OFS_DIR);
  assign hit_rel  = (addr_i == OFS_REL);
  assign hit_pol  = (addr_i == OFS_POL);
  assign hit_ien  = (addr_i == OFS_IEN);
  assign hit_pend = (addr_i == OFS_PEND);
  assign addr_ok  = hit_in | hit_out | hit_dir | hit_rel | hit_pol | hit_ien | hit_pend;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_o <= '0;
      dir_o <= '0;
      rel_o <= '0;
      pol_o <= '0;
      ien_o <= '0;
    end else if (wr) begin
      if (hit_out) out_o <= wdata_i;
      if (hit_dir) dir_o <= wdata_i;
      if (hit_rel) rel_o <= wdata_i;
      if (hit_pol) pol_o <= wdata_i;
      if (hit_ien) ien_o <= wdata_i;
    end
  end

  assign clr_o = (wr && hit_pend) ? wdata_i : '0;

  always_comb begin
    rdata_o = '0;
    if (hit_in)   rdata_o = in_val_i;
    if (hit_out)  rdata_o = out_o;
    if (hit_dir)  rdata_o = dir_o;
    if (hit_rel)  rdata_o = rel_o;
    if (hit_pol)  rdata_o = pol_o;
    if (hit_ien)  rdata_o = ien_o;
    if (hit_pend) rdata_o = pend_i;
  end

  assert_wr_dir_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == OFS_DIR) |=> (dir_o == $past(wdata_i)));

  assert_undef_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && (!addr_ok || addr_i == OFS_IN))
      |=> $stable({out_o, dir_o, rel_o, pol_o, ien_o}));
endmodule

// File: rtl/gpio_irq.sv
module gpio_irq #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] in_val_i,
  input  logic [W-1:0] pol_i,
  input  logic [W-1:0] ien_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] pend_o
);
  logic [W-1:0] prev_q, rise, fall, set_vec;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else prev_q <= in_val_i;
  end

  for (genvar n = 0; n < W; n++) begin : g_pin
    assign rise[n]    = in_val_i[n] & ~prev_q[n];
    assign fall[n]    = ~in_val_i[n] & prev_q[n];
    assign set_vec[n] = ien_i[n] & (pol_i[n] ? rise[n] : fall[n]);

    // set beats a same-cycle clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pend_o[n] <= 1'b0;
      else pend_o[n] <= set_vec[n] | (pend_o[n] & ~clr_i[n]);
    end
  end

  assert_set_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_vec) |=> ((pend_o & $past(set_vec)) == $past(set_vec)));

  assert_clear_only_by_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> ((~pend_o & $past(pend_o) & ~$past(clr_i)) == '0));

  assert_disabled_no_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> ((pend_o & ~$past(pend_o) & ~$past(ien_i)) == '0));
endmodule

// File: rtl/gpio_pad_ctl.sv
module gpio_pad_ctl #(
  parameter int W = 16
) (
  input  logic [W-1:0] out_i,
  input  logic [W-1:0] dir_i,
  input  logic [W-1:0] rel_i,
  output logic [W-1:0] pad_o,
  output logic [W-1:0] pad_oe_o
);
  for (genvar n = 0; n < W; n++) begin : g_pin
    assign pad_oe_o[n] = dir_i[n] & ~rel_i[n];
    assign pad_o[n]    = out_i[n];
  end
endmodule

// File: rtl/gpio16_ctrl.sv
module gpio16_ctrl
  import gpio_pkg::*;
#(
  parameter int NPINS       = DATA_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NPINS-1:0]  wdata_i,
  output logic [NPINS-1:0]  rdata_o,
  input  logic [NPINS-1:0]  pad_i,
  output logic [NPINS-1:0]  pad_o,
  output logic [NPINS-1:0]  pad_oe_o,
  output logic              irq_o
);
  logic [NPINS-1:0] in_val, pend, out_r, dir_r, rel_r, pol_r, ien_r, clr;

  gpio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(pad_i), .q_o(in_val)
  );

  gpio_regs #(.W(NPINS)) u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o,
    .in_val_i(in_val), .pend_i(pend),
    .out_o(out_r), .dir_o(dir_r), .rel_o(rel_r), .pol_o(pol_r), .ien_o(ien_r),
    .clr_o(clr)
  );

  gpio_irq #(.W(NPINS)) u_irq (
    .clk_i, .rst_ni, .in_val_i(in_val), .pol_i(pol_r), .ien_i(ien_r),
    .clr_i(clr), .pend_o(pend)
  );

  gpio_pad_ctl #(.W(NPINS)) u_pad (
    .out_i(out_r), .dir_i(dir_r), .rel_i(rel_r), .pad_o, .pad_oe_o
  );

  assign irq_o = |pend;

  assert_oe_gated_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pad_oe_o & ~dir_r) == '0) && ((pad_oe_o & rel_r) == '0));

  assert_irq_falls_on_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $past(|clr));
endmodule

// File: tb/gpio16_ctrl_bench.sv
module gpio16_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0, rdata, pad, pad_o, pad_oe, ext = '0;
  logic        irq;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  typedef struct { logic [15:0] exp; logic [3:0] a; string tag; } item_t;
  item_t sb_q[$];

  always #5 clk = ~clk;

  assign pad = (pad_oe & pad_o) | (~pad_oe & ext);

  gpio16_ctrl u_gpio16_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pad_i(pad), .pad_o(pad_o),
    .pad_oe_o(pad_oe), .irq_o(irq)
  );

  // monitor: compare each read against the scoreboard head
  always @(negedge clk) begin
    if (req && !we) begin
      item_t it;
      n_chk++;
      if (sb_q.size() == 0) begin
        n_bad++;
        $display("FAIL scoreboard empty addr %h got %h", addr, rdata);
      end else begin
        it = sb_q.pop_front();
        if (rdata !== it.exp) begin
          n_bad++;
          $display("FAIL %s addr %h got %h exp %h", it.tag, it.a, rdata, it.exp);
        end
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    tick(1);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [15:0] e, input string tag);
    item_t it;
    it.exp = e; it.a = a; it.tag = tag;
    sb_q.push_back(it);
    req = 1'b1; we = 1'b0; addr = a;
    tick(1);
    req = 1'b0;
  endtask

  task automatic chk(input logic [15:0] act, input logic [15:0] e, input string tag);
    n_chk++;
    if (act !== e) begin
      n_bad++;
      $display("FAIL %s got %h exp %h", tag, act, e);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1 reset state
    chk(pad_oe, 16'h0, "R1 pad_oe");
    chk(pad_o, 16'h0, "R1 pad_o");
    chk({15'h0, irq}, 16'h0, "R1 irq");
    for (int a = 2; a <= 12; a += 2) rd(4'(a), 16'h0, "R1 reset reg");

    // R2 write/readback
    wr(4'h2, 16'hA5C3); wr(4'h4, 16'hFF00); wr(4'h6, 16'h0F00);
    wr(4'h8, 16'h1234); wr(4'hA, 16'h8001);
    rd(4'h2, 16'hA5C3, "R2 out");
    rd(4'h4, 16'hFF00, "R2 dir");
    rd(4'h6, 16'h0F00, "R2 rel");
    rd(4'h8, 16'h1234, "R2 pol");
    rd(4'hA, 16'h8001, "R2 ien");
    // R3 driver gating
    chk(pad_oe, 16'hF000, "R3 pad_oe");
    chk(pad_o, 16'hA5C3, "R3 pad_o");
    // R4 input path, mixed driven and external
    ext = 16'h0CAB;
    tick(2);
    rd(4'h0, 16'hACAB, "R4 input mixed");

    // quiet setup for interrupt tests
    wr(4'hA, 16'h0); wr(4'h4, 16'h0); wr(4'h6, 16'h0);
    wr(4'h8, 16'h0); wr(4'h2, 16'h0);
    ext = 16'h0;
    tick(4);
    wr(4'hC, 16'hFFFF);
    rd(4'hC, 16'h0, "R7 clear all");
    chk({15'h0, irq}, 16'h0, "R10 irq low");

    // R5 rising on pin0, falling on pin1
    wr(4'h8, 16'h0001); wr(4'hA, 16'h0003);
    ext = 16'h0001;
    tick(2);
    chk({15'h0, irq}, 16'h0, "R5 irq not yet");
    tick(1);
    chk({15'h0, irq}, 16'h1, "R5 irq on rise");
    rd(4'hC, 16'h0001, "R5 pend rise");
    ext = 16'h0003;               // pin1 rises: wrong polarity
    tick(3);
    rd(4'hC, 16'h0001, "R6 wrong edge pin1");
    ext = 16'h0001;               // pin1 falls
    tick(3);
    rd(4'hC, 16'h0003, "R5 pend fall");
    // R6 disabled pin and wrong edge on pin0
    ext = 16'h0005; tick(3);
    ext = 16'h0001; tick(3);
    rd(4'hC, 16'h0003, "R6 disabled pin2");
    ext = 16'h0000; tick(3);
    rd(4'hC, 16'h0003, "R6 pin0 falling ignored");
    rd(4'hA, 16'h0003, "R7 ien only");

    // R7 clear semantics, R10 partial
    wr(4'hC, 16'h0001);
    rd(4'hC, 16'h0002, "R7 clear pin0");
    chk({15'h0, irq}, 16'h1, "R10 irq stays");
    wr(4'hC, 16'h0000);
    rd(4'hC, 16'h0002, "R7 zero write");
    wr(4'hC, 16'h0002);
    chk({15'h0, irq}, 16'h0, "R10 irq drops");
    rd(4'hC, 16'h0000, "R7 clear pin1");

    // R8 edge and clear in same cycle
    ext = 16'h0001; tick(3);
    rd(4'hC, 16'h0001, "R8 pre-set");
    ext = 16'h0000; tick(3);
    ext = 16'h0001;
    tick(2);
    wr(4'hC, 16'h0001);
    rd(4'hC, 16'h0001, "R8 set wins");
    wr(4'hC, 16'h0001);
    rd(4'hC, 16'h0000, "R8 later clear");

    // R9 undefined and read-only offsets
    wr(4'hE, 16'hFFFF); wr(4'h3, 16'hFFFF); wr(4'h0, 16'hFFFF); wr(4'h5, 16'hFFFF);
    rd(4'hE, 16'h0, "R9 read 0x0E");
    rd(4'h3, 16'h0, "R9 read odd");
    rd(4'h2, 16'h0, "R9 out unchanged");
    rd(4'h4, 16'h0, "R9 dir unchanged");
    rd(4'h0, 16'h0001, "R9 input unchanged");

    // R4 output pin reads back its own level
    wr(4'h4, 16'h0010); wr(4'h2, 16'h0010);
    tick(2);
    rd(4'h0, 16'h0011, "R4 output readback high");
    wr(4'h2, 16'h0000);
    tick(2);
    rd(4'h0, 16'h0001, "R4 output readback low");

    tick(2);
    chk(16'(sb_q.size()), 16'h0, "scoreboard drained");
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule